// File: doc/BRIEF.md
# Delimited Word Framer and Deframer

This block carries variable-length payloads of 32-bit words over a plain word stream. On the transmit side it accepts payload beats through a valid/ready handshake with a last flag. Each payload is wrapped between a start marker and an end marker on the line. A marker is a reserved delimiter word followed by a control word. A payload word that happens to equal the delimiter is sent twice in a row. Every line word carries one parity bit, chosen so that the 33 bits together hold an even number of ones.

The receive side watches a line word stream that has no backpressure. It finds frame boundaries by recognising the delimiter, collapses doubled delimiters back into one data word, and delivers the payload with a last flag on its final word. It reports parity errors per word. It also reports protocol errors and resynchronises on the next start marker. The two halves are independent, so they can be joined back to back through a link or used separately.

Top module: `wfr_codec`

## Requirements
- R1: A frame on the line is the delimiter 0xDEADBEEF, the control word 0x00000001 (start), the encoded payload, the delimiter again and the control word 0x00000002 (end), each sent on a cycle with tx_valid and tx_ready both high.
- R2: A payload word equal to 0xDEADBEEF is sent as two consecutive delimiter words. The deframer turns a delimiter followed directly by a second delimiter into one data word of that value.
- R3: tx_par is set so that tx_word and tx_par together contain an even number of ones.
- R4: s_ready is high only in the cycle where the payload word itself goes out on the line (tx_valid high, tx_word equal to s_data). It stays low while the framer sends delimiter, control or escape words.
- R5: The deframer delivers every payload word in order on m_data with m_valid and drops none. A word is delivered one cycle after the line word that follows it is received, either the next data word or the end control word. m_last is high only on the final word.
- R6: A start marker followed directly by an end marker makes m_empty pulse for one cycle one cycle later, and no m_valid beat is produced.
- R7: A line word received with odd parity over its 33 bits makes par_err pulse one cycle later. The word is otherwise handled normally.
- R8: proto_err pulses one cycle after any of these: a delimiter followed by a control word other than 1 or 2; a start marker inside a frame, which also discards the word held back for delivery; a data word outside a frame; an end marker outside a frame.
- R9: After a protocol error the deframer discards everything up to the next start marker. It delivers nothing and raises no further protocol error in that time.
- R10: During and right after reset, s_ready, m_valid, m_empty, par_err and proto_err are low, and the deframer is outside any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 32 | Payload word in |
| s_valid | input | 1 | Payload word valid |
| s_last | input | 1 | Payload word is the last of its frame |
| s_ready | output | 1 | Payload word accepted this cycle if s_valid |
| tx_word | output | 32 | Line word out |
| tx_par | output | 1 | Even-parity bit for tx_word |
| tx_valid | output | 1 | Line word out valid |
| tx_ready | input | 1 | Line accepts tx_word |
| rx_word | input | 32 | Line word in |
| rx_par | input | 1 | Parity bit received with rx_word |
| rx_valid | input | 1 | Line word in valid |
| m_data | output | 32 | Restored payload word |
| m_valid | output | 1 | m_data valid (one-cycle pulse) |
| m_last | output | 1 | m_data is the last word of its frame |
| m_empty | output | 1 | A zero-length frame was received |
| par_err | output | 1 | Parity error on a received word |
| proto_err | output | 1 | Framing protocol error detected |

## Verification
The hardest situations to reach are on the receive side. One is an escaped delimiter that ends a frame, so a doubled delimiter is followed at once by another delimiter and the end code. Another is a malformed stream that errors while a word is still held back and then has to resynchronise. The framer cannot produce either the malformed sequences or a zero-length frame. So the bench first loops the framer output into the deframer with random stalls on both handshakes and payloads dense with delimiter values. It then switches the deframer input to hand-written line sequences covering empty frames, unknown control codes, nested starts, stray data, stray ends and flipped parity bits.

// File: rtl/wfr_pkg.sv
package wfr_pkg;

    localparam int unsigned WORD_W_DEF = 32;

    // framer emission phase
    typedef enum logic [2:0] {
        FP_SOF_DLM,
        FP_SOF_CTL,
        FP_DATA,
        FP_ESC,
        FP_EOF_DLM,
        FP_EOF_CTL
    } fr_phase_e;

    // deframer line state
    typedef enum logic [1:0] {
        DM_IDLE,
        DM_IN,
        DM_DROP
    } df_mode_e;

endpackage

// File: rtl/wfr_parity.sv
module wfr_parity #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] word,
    output logic         odd
);
    assign odd = ^word;
endmodule

// File: rtl/wfr_framer.sv
module wfr_framer
    import wfr_pkg::*;
#(
    parameter int unsigned W   = 32,
    parameter logic [W-1:0] DELIM = 32'hDEADBEEF,
    parameter logic [W-1:0] SOF   = 32'h00000001,
    parameter logic [W-1:0] EOF   = 32'h00000002
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s_data,
    input  logic         s_valid,
    input  logic         s_last,
    output logic         s_ready,
    output logic [W-1:0] tx_word,
    output logic         tx_par,
    output logic         tx_valid,
    input  logic         tx_ready
);

    typedef struct packed {
        fr_phase_e ph;
        logic      last;
    } fr_st_t;

    fr_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        tx_word  = DELIM;
        tx_valid = 1'b0;
        s_ready  = 1'b0;
        case (st_q.ph)
            FP_SOF_DLM: begin
                tx_valid = s_valid;
                if (s_valid && tx_ready) st_d.ph = FP_SOF_CTL;
            end
            FP_SOF_CTL: begin
                tx_word  = SOF;
                tx_valid = 1'b1;
                if (tx_ready) st_d.ph = FP_DATA;
            end
            FP_DATA: begin
                tx_word  = s_data;
                tx_valid = s_valid;
                s_ready  = tx_ready;
                if (s_valid && tx_ready) begin
                    st_d.last = s_last;
                    if (s_data == DELIM) st_d.ph = FP_ESC;
                    else if (s_last)     st_d.ph = FP_EOF_DLM;
                end
            end
            FP_ESC: begin
                tx_valid = 1'b1;
                if (tx_ready) st_d.ph = st_q.last ? FP_EOF_DLM : FP_DATA;
            end
            FP_EOF_DLM: begin
                tx_valid = 1'b1;
                if (tx_ready) st_d.ph = FP_EOF_CTL;
            end
            FP_EOF_CTL: begin
                tx_word  = EOF;
                tx_valid = 1'b1;
                if (tx_ready) st_d.ph = FP_SOF_DLM;
            end
            default: st_d.ph = FP_SOF_DLM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ph   <= FP_SOF_DLM;
            st_q.last <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    wfr_parity #(.W(W)) u_par (.word(tx_word), .odd(tx_par));

    // R4
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |-> (tx_valid && tx_ready && tx_word == s_data));

    // R2
    esc_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_data == DELIM) |=> (tx_valid && tx_word == DELIM && !s_ready));

    // R1
    eof_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last && s_data != DELIM) |=> (tx_valid && tx_word == DELIM && !s_ready));

endmodule

// File: rtl/wfr_deframer.sv
module wfr_deframer
    import wfr_pkg::*;
#(
    parameter int unsigned W   = 32,
    parameter logic [W-1:0] DELIM = 32'hDEADBEEF,
    parameter logic [W-1:0] SOF   = 32'h00000001,
    parameter logic [W-1:0] EOF   = 32'h00000002
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rx_word,
    input  logic         rx_par,
    input  logic         rx_valid,
    output logic [W-1:0] m_data,
    output logic         m_valid,
    output logic         m_last,
    output logic         m_empty,
    output logic         par_err,
    output logic         proto_err
);

    typedef struct packed {
        df_mode_e     mode;
        logic         esc;
        logic         pend_vld;
        logic [W-1:0] pend;
        logic         m_valid;
        logic [W-1:0] m_data;
        logic         m_last;
        logic         m_empty;
        logic         par_err;
        logic         proto_err;
    } df_st_t;

    df_st_t st_q, st_d;
    logic   rx_odd;
    logic   is_dlm;
    logic   take_data;
    logic   bad;

    wfr_parity #(.W(W)) u_chk (.word(rx_word), .odd(rx_odd));

    assign is_dlm = (rx_word == DELIM);

    always_comb begin
        st_d           = st_q;
        st_d.m_valid   = 1'b0;
        st_d.m_last    = 1'b0;
        st_d.m_empty   = 1'b0;
        st_d.par_err   = 1'b0;
        st_d.proto_err = 1'b0;
        take_data      = 1'b0;
        bad            = 1'b0;
        if (rx_valid) begin
            st_d.par_err = rx_odd ^ rx_par;
            if (st_q.esc) begin
                st_d.esc = 1'b0;
                if (is_dlm) begin
                    take_data = 1'b1;
                end else if (rx_word == SOF) begin
                    if (st_q.mode == DM_IN) begin
                        bad = 1'b1;
                    end else begin
                        st_d.mode     = DM_IN;
                        st_d.pend_vld = 1'b0;
                    end
                end else if (rx_word == EOF) begin
                    if (st_q.mode == DM_IN) begin
                        if (st_q.pend_vld) begin
                            st_d.m_valid = 1'b1;
                            st_d.m_data  = st_q.pend;
                            st_d.m_last  = 1'b1;
                        end else begin
                            st_d.m_empty = 1'b1;
                        end
                        st_d.pend_vld = 1'b0;
                        st_d.mode     = DM_IDLE;
                    end else begin
                        bad = 1'b1;
                    end
                end else begin
                    bad = 1'b1;
                end
            end else if (is_dlm) begin
                st_d.esc = 1'b1;
            end else begin
                take_data = 1'b1;
            end

            if (take_data) begin
                if (st_q.mode == DM_IN) begin
                    if (st_q.pend_vld) begin
                        st_d.m_valid = 1'b1;
                        st_d.m_data  = st_q.pend;
                    end
                    st_d.pend     = rx_word;
                    st_d.pend_vld = 1'b1;
                end else begin
                    bad = 1'b1;
                end
            end

            if (bad && st_q.mode != DM_DROP) begin
                st_d.proto_err = 1'b1;
                st_d.mode      = DM_DROP;
                st_d.pend_vld  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode      <= DM_IDLE;
            st_q.esc       <= 1'b0;
            st_q.pend_vld  <= 1'b0;
            st_q.pend      <= '0;
            st_q.m_valid   <= 1'b0;
            st_q.m_data    <= '0;
            st_q.m_last    <= 1'b0;
            st_q.m_empty   <= 1'b0;
            st_q.par_err   <= 1'b0;
            st_q.proto_err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_data    = st_q.m_data;
    assign m_valid   = st_q.m_valid;
    assign m_last    = st_q.m_last;
    assign m_empty   = st_q.m_empty;
    assign par_err   = st_q.par_err;
    assign proto_err = st_q.proto_err;

    // R5
    beat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> $past(rx_valid));

    // R6
    empty_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_empty |-> ($past(rx_valid) && $past(rx_word) == EOF && !m_valid));

    // R7
    par_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(rx_valid));

    // R9
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> (!proto_err && !m_valid && !m_empty));

endmodule

// File: rtl/wfr_codec.sv
module wfr_codec
    import wfr_pkg::*;
#(
    parameter int unsigned W     = WORD_W_DEF,
    parameter logic [W-1:0] DELIM = 32'hDEADBEEF,
    parameter logic [W-1:0] SOF   = 32'h00000001,
    parameter logic [W-1:0] EOF   = 32'h00000002
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s_data,
    input  logic         s_valid,
    input  logic         s_last,
    output logic         s_ready,
    output logic [W-1:0] tx_word,
    output logic         tx_par,
    output logic         tx_valid,
    input  logic         tx_ready,
    input  logic [W-1:0] rx_word,
    input  logic         rx_par,
    input  logic         rx_valid,
    output logic [W-1:0] m_data,
    output logic         m_valid,
    output logic         m_last,
    output logic         m_empty,
    output logic         par_err,
    output logic         proto_err
);

    wfr_framer #(.W(W), .DELIM(DELIM), .SOF(SOF), .EOF(EOF)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_data   (s_data),
        .s_valid  (s_valid),
        .s_last   (s_last),
        .s_ready  (s_ready),
        .tx_word  (tx_word),
        .tx_par   (tx_par),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready)
    );

    wfr_deframer #(.W(W), .DELIM(DELIM), .SOF(SOF), .EOF(EOF)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_word   (rx_word),
        .rx_par    (rx_par),
        .rx_valid  (rx_valid),
        .m_data    (m_data),
        .m_valid   (m_valid),
        .m_last    (m_last),
        .m_empty   (m_empty),
        .par_err   (par_err),
        .proto_err (proto_err)
    );

endmodule

// File: tb/wfr_codec_tb.sv
module wfr_codec_tb;

    localparam logic [31:0] DLM = 32'hDEADBEEF;
    localparam logic [31:0] CS  = 32'h00000001;
    localparam logic [31:0] CE  = 32'h00000002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_valid = 1'b0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic [31:0] tx_word;
    logic        tx_par;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] d_word = '0;
    logic        d_par = 1'b0;
    logic        d_valid = 1'b0;
    logic        lb = 1'b0;
    logic [31:0] rx_word;
    logic        rx_par;
    logic        rx_valid;
    logic [31:0] m_data;
    logic        m_valid, m_last, m_empty, par_err, proto_err;

    assign rx_word  = lb ? tx_word : d_word;
    assign rx_par   = lb ? tx_par : d_par;
    assign rx_valid = lb ? (tx_valid && tx_ready) : d_valid;

    always #4 clk = ~clk;

    wfr_codec u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .tx_word(tx_word), .tx_par(tx_par), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_word(rx_word), .rx_par(rx_par), .rx_valid(rx_valid),
        .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_empty(m_empty),
        .par_err(par_err), .proto_err(proto_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // framer side reference
    logic [32:0] beats[$];   // {last, data}
    logic [31:0] exp_tx[$];
    bit          exp_isdata[$];
    logic [32:0] sent[$];    // payload words expected back in loopback
    bit          hold = 1'b0;

    // deframer reference
    int          mmode = 0;  // 0 outside, 1 inside, 2 discarding
    bit          mesc = 1'b0;
    logic [31:0] mpend[$];
    bit          e_mv = 0, e_ml = 0, e_me = 0, e_pa = 0, e_pr = 0;
    logic [31:0] e_md = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic add_frame(input logic [31:0] w[$]);
        exp_tx.push_back(DLM); exp_isdata.push_back(0);
        exp_tx.push_back(CS);  exp_isdata.push_back(0);
        foreach (w[i]) begin
            beats.push_back({(i == w.size() - 1), w[i]});
            sent.push_back({(i == w.size() - 1), w[i]});
            exp_tx.push_back(w[i]); exp_isdata.push_back(1);
            if (w[i] == DLM) begin
                exp_tx.push_back(DLM); exp_isdata.push_back(0);
            end
        end
        exp_tx.push_back(DLM); exp_isdata.push_back(0);
        exp_tx.push_back(CE);  exp_isdata.push_back(0);
    endtask

    task automatic model_emit(input logic [31:0] w, input bit last);
        e_mv = 1; e_md = w; e_ml = last;
    endtask

    task automatic model_step(input bit v, input logic [31:0] w, input bit p);
        bit data_word;
        bit err;
        data_word = 0; err = 0;
        e_mv = 0; e_ml = 0; e_me = 0; e_pa = 0; e_pr = 0;
        if (!v) return;
        e_pa = ((^w) != p);
        if (mesc) begin
            mesc = 0;
            if (w == DLM) data_word = 1;
            else if (w == CS) begin
                if (mmode == 1) err = 1;
                else begin mmode = 1; mpend.delete(); end
            end else if (w == CE) begin
                if (mmode == 1) begin
                    if (mpend.size() > 0) model_emit(mpend.pop_front(), 1);
                    else e_me = 1;
                    mmode = 0;
                end else err = 1;
            end else err = 1;
        end else if (w == DLM) mesc = 1;
        else data_word = 1;
        if (data_word) begin
            if (mmode == 1) begin
                if (mpend.size() > 0) model_emit(mpend.pop_front(), 0);
                mpend.push_back(w);
            end else err = 1;
        end
        if (err && mmode != 2) begin
            e_pr = 1; mmode = 2; mpend.delete();
        end
    endtask

    task automatic cyc(input bit dv, input logic [31:0] dw, input bit flip);
        logic [32:0] got;
        @(negedge clk);
        // outputs of the previous edge
        chk(m_valid == e_mv, "R5 m_valid", {63'd0, m_valid}, {63'd0, e_mv});
        if (e_mv) begin
            chk(m_data == e_md && m_last == e_ml, "R2 R5 m_data/m_last",
                {31'd0, m_last, m_data}, {31'd0, e_ml, e_md});
            if (lb) begin
                got = sent.pop_front();
                chk({m_last, m_data} == got, "R5 loopback payload", {31'd0, m_last, m_data}, {31'd0, got});
            end
        end
        chk(m_empty == e_me, "R6 m_empty", {63'd0, m_empty}, {63'd0, e_me});
        chk(par_err == e_pa, "R7 par_err", {63'd0, par_err}, {63'd0, e_pa});
        chk(proto_err == e_pr, "R8 R9 proto_err", {63'd0, proto_err}, {63'd0, e_pr});
        // drive
        if (!hold) begin
            s_valid = (beats.size() > 0) && ($urandom_range(3) != 0);
            if (beats.size() > 0) {s_last, s_data} = beats[0];
        end
        tx_ready = lb && ($urandom_range(2) != 0);
        d_valid = dv; d_word = dw; d_par = (^dw) ^ flip;
        #1;
        if (tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) begin
                chk(0, "R1 unexpected tx word", {32'd0, tx_word}, 64'd0);
            end else begin
                chk(tx_word == exp_tx[0], "R1 R2 tx_word", {32'd0, tx_word}, {32'd0, exp_tx[0]});
                chk(s_ready == exp_isdata[0], "R4 s_ready", {63'd0, s_ready}, {63'd0, exp_isdata[0]});
                void'(exp_tx.pop_front());
                void'(exp_isdata.pop_front());
            end
            chk((^{tx_word, tx_par}) == 1'b0, "R3 tx_par", {63'd0, tx_par}, {63'd0, ^tx_word});
        end
        if (s_valid && s_ready) begin
            void'(beats.pop_front());
            hold = 0;
        end else hold = s_valid;
        model_step(rx_valid, rx_word, rx_par);
    endtask

    task automatic line(input logic [31:0] w);
        cyc(1, w, 0);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] fr[$];
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(!s_ready && !m_valid && !m_empty && !par_err && !proto_err, "R10 reset outputs",
            {59'd0, s_ready, m_valid, m_empty, par_err, proto_err}, 64'd0);
        rst_n = 1'b1;

        // loopback: framer into deframer
        lb = 1'b1;
        fr = '{32'h11111111};                               add_frame(fr);
        fr = '{DLM};                                        add_frame(fr);
        fr = '{32'hA, DLM, 32'hB};                          add_frame(fr);
        fr = '{DLM, DLM, 32'h0, 32'h2, 32'h1};              add_frame(fr);
        fr = '{32'h1, 32'h2, DLM};                          add_frame(fr);
        for (int f = 0; f < 20; f++) begin
            fr.delete();
            for (int k = 0; k <= $urandom_range(5); k++)
                fr.push_back(($urandom_range(2) == 0) ? DLM : $urandom());
            add_frame(fr);
        end
        for (int t = 0; t < 3000 && (exp_tx.size() > 0 || beats.size() > 0); t++) cyc(0, 0, 0);
        repeat (3) cyc(0, 0, 0);
        chk(exp_tx.size() == 0, "R1 all line words sent", {32'd0, exp_tx.size()}, 64'd0);
        chk(sent.size() == 0, "R5 all payload restored", {32'd0, sent.size()}, 64'd0);

        // direct line stimulus
        lb = 1'b0;
        s_valid = 0; hold = 0;
        // R6 empty frame
        line(DLM); line(CS); line(DLM); line(CE); cyc(0, 0, 0);
        // R2 escaped delimiter ending a frame
        line(DLM); line(CS); line(32'h5); line(DLM); line(DLM); line(DLM); line(CE); cyc(0, 0, 0);
        // R8 unknown control, R9 discard until start
        line(DLM); line(CS); line(32'h7); line(DLM); line(32'h9);
        line(32'h33); line(DLM); line(CE); line(DLM); line(32'h77); line(DLM); line(DLM);
        line(DLM); line(CS); line(32'h44); line(DLM); line(CE); cyc(0, 0, 0);
        // R8 start inside a frame drops held word
        line(DLM); line(CS); line(32'h66); line(DLM); line(CS);
        line(DLM); line(CS); line(32'h67); line(DLM); line(CE);
        // R8 data outside a frame, end outside a frame
        line(32'h123); line(DLM); line(CS); line(DLM); line(CE);
        line(DLM); line(CE); line(DLM); line(CS); line(DLM); line(CE);
        // R7 flipped parity on data and control words
        line(DLM); cyc(1, CS, 1); line(32'hF0F0); cyc(1, 32'h0F0F, 1); cyc(1, DLM, 1); line(CE);
        // random words, with mixed parity and markers
        for (int t = 0; t < 400; t++) begin
            case ($urandom_range(5))
                0, 1: cyc(1, DLM, $urandom_range(9) == 0);
                2:    cyc(1, CS, 0);
                3:    cyc(1, CE, 0);
                4:    cyc(1, $urandom_range(4), $urandom_range(9) == 0);
                default: cyc($urandom_range(1), $urandom(), 0);
            endcase
        end
        repeat (3) cyc(0, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule